// File: doc/BRIEF.md
# Prioritised Reset Sequencer with Watchdog Actions

This block sequences resets for a multi-core device from a single system clock. It takes an asynchronous power-on reset, a full-reset pin, a hard/soft reset pin and one expiry event per core watchdog. On the output side it drives a per-core local reset, a per-core non-maskable interrupt (NMI), a device hard-reset request, and a reset-status line that is high only while the device is out of reset.

Both reset pins pass through a two-flop synchroniser. A low pulse on a pin becomes a request only if it is long enough. After a request qualifies, reset status drops and stays low for a fixed number of cycles. A watchdog expiry runs the action held in a small set of configuration fields, aimed at the configured core. The actions are a local reset, an NMI, an NMI followed by a programmable delay and then a local reset, or a device hard-reset request. The configuration is written through a plain write strobe.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n_i` is low, `rst_stat_o`, `lrst_o`, `nmi_o` and `hrst_req_o` are all low. After `por_n_i` is released, `rst_stat_o` rises HOLD_CYCLES+2 clock edges after the first edge that samples it high. Power-on also restores the configuration to action 0, core 0, delay 0.
- R2: A pin low pulse is a request only if the pin is sampled low on at least PULSE_MIN consecutive clock edges. A shorter pulse leaves `rst_stat_o` high.
- R3: For a qualifying pulse, `rst_stat_o` falls after the fourth edge that samples the pin high again. It then stays low for exactly HOLD_CYCLES cycles.
- R4: While `rst_stat_o` is low, a qualifying hard/soft pulse is ignored: the release time of `rst_stat_o` does not move.
- R5: The configuration survives a hard/soft sequence. A qualifying full-reset pulse restores the defaults. When both pins qualify on the same edge, the full-reset handling wins.
- R6: Action 0 (`cfg_act_i`=0) drives `lrst_o` one-hot at bit `cfg_core_i`. It starts the cycle after the watchdog event and lasts LRST_LEN cycles.
- R7: Action 1 drives a single-cycle pulse on `nmi_o` bit `cfg_core_i`, with no local reset.
- R8: Action 2 pulses `nmi_o` for the selected core. `lrst_o` for that core then rises `cfg_dly_i`+1 cycles after the NMI, so a delay of 0 gives the reset in the next cycle. It lasts LRST_LEN cycles.
- R9: Action 3 drives `hrst_req_o` high for exactly one cycle.
- R10: A power-on reset during a pending escalation delay cancels the local reset that would have followed.
- R11: A watchdog event is a rising edge on any bit of `wdt_exp_i`. It is ignored while `rst_stat_o` is low, and also while an earlier action is still in its delay or local-reset phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| full_rst_n_i | input | 1 | Full-reset pin, active low, asynchronous |
| hs_rst_n_i | input | 1 | Hard/soft reset pin, active low, asynchronous |
| wdt_exp_i | input | NUM_CORES | Watchdog expiry, one bit per core |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_core_i | input | $clog2(NUM_CORES) | Target core for watchdog actions |
| cfg_act_i | input | 2 | Action code 0..3 |
| cfg_dly_i | input | DLY_W | Escalation delay in cycles |
| lrst_o | output | NUM_CORES | Per-core local reset |
| nmi_o | output | NUM_CORES | Per-core non-maskable interrupt pulse |
| hrst_req_o | output | 1 | Device hard-reset request pulse |
| rst_stat_o | output | 1 | High when the device is out of reset |

## Verification
The hardest case to reach is a power-on reset that arrives while an escalation is counting its delay. The NMI has already been issued and the local reset is still pending. The bench sets a long delay, fires the watchdog, checks the NMI, and asserts power-on a few cycles later. It then watches `lrst_o` stay quiet through the whole power-on hold. A second hard case is a qualifying hard/soft pulse and a watchdog edge that both land inside an ongoing hold window. The bench places them at fixed cycle offsets from the fall of `rst_stat_o`, so the unchanged release time can be checked exactly.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        ACT_LRST     = 2'd0,
        ACT_NMI      = 2'd1,
        ACT_NMI_LRST = 2'd2,
        ACT_HRST     = 2'd3
    } wd_act_e;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_WAIT = 2'd1,
        WD_LRST = 2'd2
    } wd_st_e;

    typedef enum logic {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_st_e;

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter logic INIT = 1'b0
) (
    input  logic clk_i,
    input  logic arst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            s1_q <= INIT;
            s2_q <= INIT;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/rstc_pulse_qual.sv
module rstc_pulse_qual #(
    parameter int MIN_W = 500
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pin_n_i,
    output logic ok_o
);
    localparam int CW = $clog2(MIN_W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev;
        logic          ok;
    } qual_t;

    qual_t q_d, q_q;

    always_comb begin
        q_d      = q_q;
        q_d.prev = pin_n_i;
        q_d.ok   = 1'b0;
        if (!pin_n_i) begin
            if (q_q.cnt != CW'(MIN_W)) begin
                q_d.cnt = q_q.cnt + 1'b1;
            end
        end else if (!q_q.prev) begin
            q_d.ok  = (q_q.cnt == CW'(MIN_W));
            q_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            q_q <= '{cnt: '0, prev: 1'b1, ok: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign ok_o = q_q.ok;
endmodule

// File: rtl/rstc_wdt_act.sv
module rstc_wdt_act
    import rstc_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int DLY_W     = 16,
    parameter int LRST_LEN  = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_n_i,
    input  logic                         clr_i,
    input  logic                         en_i,
    input  logic [NUM_CORES-1:0]         evt_i,
    input  wd_act_e                      act_i,
    input  logic [$clog2(NUM_CORES)-1:0] core_i,
    input  logic [DLY_W-1:0]             dly_i,
    output logic [NUM_CORES-1:0]         lrst_o,
    output logic [NUM_CORES-1:0]         nmi_o,
    output logic                         hrst_o
);
    localparam int CSW = $clog2(NUM_CORES);
    localparam int LW  = $clog2(LRST_LEN);

    typedef struct packed {
        wd_st_e                 st;
        logic [DLY_W-1:0]       dcnt;
        logic [LW-1:0]          lcnt;
        logic [CSW-1:0]         core;
        logic [NUM_CORES-1:0]   nmi;
        logic                   hrst;
        logic [NUM_CORES-1:0]   prev;
    } wd_t;

    wd_t w_d, w_q;
    logic trig;

    assign trig = |(evt_i & ~w_q.prev);

    always_comb begin
        w_d      = w_q;
        w_d.prev = evt_i;
        w_d.nmi  = '0;
        w_d.hrst = 1'b0;
        if (clr_i) begin
            w_d.st   = WD_IDLE;
            w_d.dcnt = '0;
            w_d.lcnt = '0;
        end else begin
            unique case (w_q.st)
                WD_IDLE: begin
                    if (trig && en_i) begin
                        w_d.core = core_i;
                        unique case (act_i)
                            ACT_LRST: begin
                                w_d.st   = WD_LRST;
                                w_d.lcnt = LW'(LRST_LEN - 1);
                            end
                            ACT_NMI: begin
                                w_d.nmi[core_i] = 1'b1;
                            end
                            ACT_NMI_LRST: begin
                                w_d.nmi[core_i] = 1'b1;
                                w_d.st          = WD_WAIT;
                                w_d.dcnt        = dly_i;
                            end
                            default: begin
                                w_d.hrst = 1'b1;
                            end
                        endcase
                    end
                end
                WD_WAIT: begin
                    if (w_q.dcnt == '0) begin
                        w_d.st   = WD_LRST;
                        w_d.lcnt = LW'(LRST_LEN - 1);
                    end else begin
                        w_d.dcnt = w_q.dcnt - 1'b1;
                    end
                end
                WD_LRST: begin
                    if (w_q.lcnt == '0) begin
                        w_d.st = WD_IDLE;
                    end else begin
                        w_d.lcnt = w_q.lcnt - 1'b1;
                    end
                end
                default: w_d.st = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            w_q <= '{st: WD_IDLE, dcnt: '0, lcnt: '0, core: '0,
                     nmi: '0, hrst: 1'b0, prev: '0};
        end else begin
            w_q <= w_d;
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign lrst_o[c] = (w_q.st == WD_LRST) && (w_q.core == CSW'(c));
    end

    assign nmi_o  = w_q.nmi;
    assign hrst_o = w_q.hrst;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstc_pkg::*;
#(
    parameter int NUM_CORES   = 8,
    parameter int PULSE_MIN   = 500,
    parameter int HOLD_CYCLES = 50000,
    parameter int LRST_LEN    = 16,
    parameter int DLY_W       = 16
) (
    input  logic                         clk_i,
    input  logic                         por_n_i,
    input  logic                         full_rst_n_i,
    input  logic                         hs_rst_n_i,
    input  logic [NUM_CORES-1:0]         wdt_exp_i,
    input  logic                         cfg_we_i,
    input  logic [$clog2(NUM_CORES)-1:0] cfg_core_i,
    input  logic [1:0]                   cfg_act_i,
    input  logic [DLY_W-1:0]             cfg_dly_i,
    output logic [NUM_CORES-1:0]         lrst_o,
    output logic [NUM_CORES-1:0]         nmi_o,
    output logic                         hrst_req_o,
    output logic                         rst_stat_o
);
    localparam int CSW = $clog2(NUM_CORES);
    localparam int HW  = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [HW-1:0]    cnt;
        wd_act_e          act;
        logic [CSW-1:0]   core;
        logic [DLY_W-1:0] dly;
    } seq_t;

    logic rst_n_int;
    logic full_s, hs_s;
    logic full_ok, hs_ok;
    logic seq_start;
    seq_t s_d, s_q;

    rstc_sync #(.INIT(1'b0)) u_por_sync (
        .clk_i(clk_i), .arst_n_i(por_n_i), .d_i(1'b1), .q_o(rst_n_int)
    );
    rstc_sync #(.INIT(1'b1)) u_full_sync (
        .clk_i(clk_i), .arst_n_i(rst_n_int), .d_i(full_rst_n_i), .q_o(full_s)
    );
    rstc_sync #(.INIT(1'b1)) u_hs_sync (
        .clk_i(clk_i), .arst_n_i(rst_n_int), .d_i(hs_rst_n_i), .q_o(hs_s)
    );

    rstc_pulse_qual #(.MIN_W(PULSE_MIN)) u_full_qual (
        .clk_i(clk_i), .rst_n_i(rst_n_int), .pin_n_i(full_s), .ok_o(full_ok)
    );
    rstc_pulse_qual #(.MIN_W(PULSE_MIN)) u_hs_qual (
        .clk_i(clk_i), .rst_n_i(rst_n_int), .pin_n_i(hs_s), .ok_o(hs_ok)
    );

    // Full reset ranks above hard/soft; hard/soft only accepted while running.
    assign seq_start = full_ok || (hs_ok && (s_q.st == SEQ_RUN));

    always_comb begin
        s_d = s_q;
        if (seq_start) begin
            s_d.st  = SEQ_HOLD;
            s_d.cnt = '0;
            if (full_ok) begin
                s_d.act  = ACT_LRST;
                s_d.core = '0;
                s_d.dly  = '0;
            end
        end else begin
            if (s_q.st == SEQ_HOLD) begin
                if (s_q.cnt == HW'(HOLD_CYCLES - 1)) begin
                    s_d.st = SEQ_RUN;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (cfg_we_i) begin
                s_d.act  = wd_act_e'(cfg_act_i);
                s_d.core = cfg_core_i;
                s_d.dly  = cfg_dly_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_int) begin
        if (!rst_n_int) begin
            s_q <= '{st: SEQ_HOLD, cnt: '0, act: ACT_LRST, core: '0, dly: '0};
        end else begin
            s_q <= s_d;
        end
    end

    rstc_wdt_act #(
        .NUM_CORES(NUM_CORES), .DLY_W(DLY_W), .LRST_LEN(LRST_LEN)
    ) u_wdt (
        .clk_i  (clk_i),
        .rst_n_i(rst_n_int),
        .clr_i  (seq_start),
        .en_i   (s_q.st == SEQ_RUN),
        .evt_i  (wdt_exp_i),
        .act_i  (s_q.act),
        .core_i (s_q.core),
        .dly_i  (s_q.dly),
        .lrst_o (lrst_o),
        .nmi_o  (nmi_o),
        .hrst_o (hrst_req_o)
    );

    assign rst_stat_o = (s_q.st == SEQ_RUN);
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
    parameter int NUM_CORES = 8,
    parameter int LRST_LEN  = 16
) (
    input logic                 clk_i,
    input logic                 por_n_i,
    input logic [NUM_CORES-1:0] lrst_o,
    input logic [NUM_CORES-1:0] nmi_o,
    input logic                 hrst_req_o,
    input logic                 rst_stat_o
);
    localparam int LCW = $clog2(LRST_LEN + 1) + 1;
    logic [LCW-1:0] lcnt;

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            lcnt <= '0;
        end else if (lrst_o != '0) begin
            if (lcnt != '1) lcnt <= lcnt + 1'b1;
        end else begin
            lcnt <= '0;
        end
    end

    AST_LRST_ONEHOT: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $onehot0(lrst_o)); // R6
    AST_NMI_ONEHOT: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $onehot0(nmi_o)); // R7
    AST_NMI_SINGLE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (nmi_o != '0) |=> (nmi_o == '0)); // R7
    AST_HRST_SINGLE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        hrst_req_o |=> !hrst_req_o); // R9
    AST_QUIET_IN_RESET: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !rst_stat_o |-> (lrst_o == '0 && nmi_o == '0 && !hrst_req_o)); // R11
    AST_STAT_MIN_LOW: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(rst_stat_o) |=> !rst_stat_o); // R3
    AST_LRST_LENGTH: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (lrst_o == '0 && lcnt != '0 && rst_stat_o) |-> (lcnt == LCW'(LRST_LEN))); // R6
endmodule

bind rst_sequencer rstc_checker #(
    .NUM_CORES(NUM_CORES), .LRST_LEN(LRST_LEN)
) chk_i (
    .clk_i(clk_i), .por_n_i(por_n_i), .lrst_o(lrst_o), .nmi_o(nmi_o),
    .hrst_req_o(hrst_req_o), .rst_stat_o(rst_stat_o)
);

// File: tb/rst_sequencer_tb_top.sv
module rst_sequencer_tb_top;
    localparam int NC   = 8;
    localparam int PMIN = 10;
    localparam int HOLD = 100;
    localparam int LLEN = 16;
    localparam int DW   = 8;

    logic          clk = 1'b0;
    logic          por_n = 1'b1;
    logic          full_n = 1'b1;
    logic          hs_n = 1'b1;
    logic [NC-1:0] wdt = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_core = '0;
    logic [1:0]    cfg_act = '0;
    logic [DW-1:0] cfg_dly = '0;
    logic [NC-1:0] lrst, nmi;
    logic          hrst, stat;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rst_sequencer #(
        .NUM_CORES(NC), .PULSE_MIN(PMIN), .HOLD_CYCLES(HOLD),
        .LRST_LEN(LLEN), .DLY_W(DW)
    ) dut_i (
        .clk_i(clk), .por_n_i(por_n), .full_rst_n_i(full_n), .hs_rst_n_i(hs_n),
        .wdt_exp_i(wdt), .cfg_we_i(cfg_we), .cfg_core_i(cfg_core),
        .cfg_act_i(cfg_act), .cfg_dly_i(cfg_dly), .lrst_o(lrst), .nmi_o(nmi),
        .hrst_req_o(hrst), .rst_stat_o(stat)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg(int act, int core, int dly);
        cfg_act = 2'(act); cfg_core = 3'(core); cfg_dly = DW'(dly);
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic fire(int bitn);
        wdt[bitn] = 1'b1;
        tick();
        wdt = '0;
    endtask

    task automatic wait_lrst_end(int core, string req);
        int bad = 0;
        for (int i = 0; i < LLEN - 1; i++) begin
            tick();
            if (lrst != NC'(1 << core)) bad++;
        end
        chk(bad == 0, req, "lrst held cycles", bad, 0);
        tick();
        chk(lrst == '0, req, "lrst released after LRST_LEN", lrst, 0);
    endtask

    // Drive selected pins low for n sampled edges, then check status timing.
    task automatic pin_seq(bit use_full, bit use_hs, int n, string req);
        int bad = 0;
        if (use_full) full_n = 1'b0;
        if (use_hs)   hs_n = 1'b0;
        repeat (n) tick();
        full_n = 1'b1; hs_n = 1'b1;
        repeat (3) tick();
        chk(stat == 1'b1, req, "stat before fall", stat, 1);
        tick();
        chk(stat == 1'b0, req, "stat falls 4th edge", stat, 0);
        for (int i = 0; i < HOLD - 1; i++) begin
            tick();
            if (stat != 1'b0) bad++;
        end
        chk(bad == 0, req, "stat low window", bad, 0);
        tick();
        chk(stat == 1'b1, req, "stat release after HOLD", stat, 1);
    endtask

    task automatic t_por(string req);
        int bad = 0;
        por_n = 1'b0;
        repeat (3) tick();
        chk(stat == 0 && lrst == 0 && nmi == 0 && hrst == 0, req,
            "outputs during POR", {stat, hrst, lrst, nmi}, 0);
        por_n = 1'b1;
        for (int i = 0; i < HOLD + 1; i++) begin
            tick();
            if (stat != 1'b0 || lrst != '0) bad++;
        end
        chk(bad == 0, req, "stat low after POR release", bad, 0);
        tick();
        chk(stat == 1'b1, req, "stat rises HOLD+2", stat, 1);
    endtask

    task automatic t_short();
        int bad = 0;
        hs_n = 1'b0;
        repeat (PMIN - 1) tick();
        hs_n = 1'b1;
        repeat (20) begin
            tick();
            if (stat != 1'b1) bad++;
        end
        chk(bad == 0, "R2", "short pulse ignored", bad, 0);
    endtask

    task automatic t_local();
        cfg(0, 3, 0);
        fire(6);
        chk(lrst == 8'h08 && nmi == 0, "R6", "lrst core3 starts", lrst, 8'h08);
        wait_lrst_end(3, "R6");
    endtask

    task automatic t_nmi();
        cfg(1, 5, 0);
        fire(0);
        chk(nmi == 8'h20 && lrst == 0, "R7", "nmi core5", nmi, 8'h20);
        tick();
        chk(nmi == 0 && lrst == 0, "R7", "nmi single cycle", nmi, 0);
    endtask

    task automatic t_esc(int d);
        int bad = 0;
        cfg(2, 2, d);
        fire(0);
        chk(nmi == 8'h04 && lrst == 0, "R8", "escalation nmi", nmi, 8'h04);
        for (int i = 1; i <= d; i++) begin
            if (i == 1) wdt[1] = 1'b1;
            tick();
            if (i == 1) begin
                wdt = '0;
                chk(nmi == 0, "R11", "event ignored in delay", nmi, 0);
            end
            if (lrst != 0) bad++;
        end
        chk(bad == 0, "R8", "no lrst during delay", bad, 0);
        tick();
        chk(lrst == 8'h04, "R8", "lrst after delay+1", lrst, 8'h04);
        wait_lrst_end(2, "R8");
    endtask

    task automatic t_hrst();
        cfg(3, 1, 0);
        fire(4);
        chk(hrst == 1'b1 && nmi == 0 && lrst == 0, "R9", "hrst pulse", hrst, 1);
        tick();
        chk(hrst == 1'b0, "R9", "hrst single cycle", hrst, 0);
    endtask

    task automatic t_retain();
        cfg(1, 5, 0);
        pin_seq(1'b0, 1'b1, PMIN + 3, "R5");
        fire(7);
        chk(nmi == 8'h20, "R5", "config kept over hard/soft", nmi, 8'h20);
        tick();
    endtask

    task automatic t_full_both();
        cfg(1, 6, 0);
        pin_seq(1'b1, 1'b1, PMIN, "R5");
        fire(2);
        chk(lrst == 8'h01 && nmi == 0, "R5", "full wins, defaults", lrst, 8'h01);
        wait_lrst_end(0, "R5");
    endtask

    task automatic t_busy();
        int bad = 0;
        cfg(1, 4, 0);
        hs_n = 1'b0;
        repeat (PMIN) tick();
        hs_n = 1'b1;
        repeat (4) tick();
        chk(stat == 1'b0, "R4", "sequence started", stat, 0);
        repeat (5) tick();
        hs_n = 1'b0;
        repeat (PMIN + 2) tick();
        hs_n = 1'b1;
        repeat (10) tick();
        fire(3);
        chk(nmi == 0 && lrst == 0, "R11", "event ignored in hold", nmi, 0);
        for (int i = 0; i < HOLD - 1 - (5 + PMIN + 2 + 10 + 1); i++) begin
            tick();
            if (stat != 1'b0) bad++;
        end
        chk(bad == 0, "R4", "hold not shortened", bad, 0);
        tick();
        chk(stat == 1'b1, "R4", "release time unchanged", stat, 1);
    endtask

    task automatic t_por_abort();
        int bad = 0;
        cfg(2, 1, 50);
        fire(5);
        chk(nmi == 8'h02, "R10", "nmi before abort", nmi, 8'h02);
        repeat (5) tick();
        por_n = 1'b0;
        repeat (2) tick();
        por_n = 1'b1;
        for (int i = 0; i < HOLD + 60; i++) begin
            tick();
            if (lrst != 0) bad++;
        end
        chk(bad == 0, "R10", "lrst cancelled by POR", bad, 0);
        chk(stat == 1'b1, "R1", "status back after POR", stat, 1);
        fire(1);
        chk(lrst == 8'h01, "R1", "defaults after POR", lrst, 8'h01);
        wait_lrst_end(0, "R1");
    endtask

    initial begin
        #2;
        t_por("R1");
        pin_seq(1'b0, 1'b1, PMIN, "R3");
        pin_seq(1'b0, 1'b1, PMIN, "R2");
        t_short();
        t_local();
        t_nmi();
        t_esc(0);
        t_esc(5);
        t_hrst();
        t_retain();
        t_full_both();
        t_busy();
        t_por_abort();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule